// File: doc/BRIEF.md
# Protection Fault Sequencer

This block is the supervisory state machine of a primary-side LED driver controller. It decides when the gate driver may switch. It watches the supply-level flags, a line-sense comparator and a set of fault flags. When a fault arrives it stops the drive and runs the restart sequence. The sequence waits for the supply to discharge, runs a long auto-recovery timer and returns to start-up. It holds the drive off for a settling interval before switching resumes.

Two fault classes exist. Recoverable faults restart on their own. Latched faults, which apply only when the latched variant is selected, keep the drive off until the supply-reset condition appears. The pin over-voltage and over-temperature flags must persist before they count. A low line must persist for a blanking interval before it stops the drive. When the line recovers, the controller returns to start-up at once and does not wait for the supply to discharge.

Every duration is a parameter counted in clock cycles: the start-up hold-off, the fault confirmation filter, the restart timer and the line blanking. A variant with a shorter line blanking interval is built by overriding the blanking parameter.

Top module: `fault_seq`

## Requirements
- R1: After reset the state code is 0 (start-up), `drv_en` is 0 and `startup_mode` is 1. The state codes are: 0 start-up, 1 stopped, 2 running, 3 discharging, 4 restart timer, 5 latched. Codes 6 and 7 never appear.
- R2: In start-up, with `vcc_on` high and no brown-out, the machine enters the stopped state (code 1). It stays there for exactly HOLD_CYC cycles and then moves to running (code 2). `drv_en` is high only while running.
- R3: `f_otp` and `f_pin_ovp` have an effect only after they have been high for CONFIRM_CYC consecutive cycles. A pulse one cycle shorter leaves the running state unchanged. After confirmation the drive stops one cycle later.
- R4: A recoverable timed fault (`f_otp`, `f_pin_ovp`, `f_vcc_ovp`, and `f_wod` or `f_aux` with `latch_sel` low) moves the machine from stopped or running to discharging (code 3). `vcc_off` then starts the restart timer (code 4). After RESTART_CYC cycles the machine returns to start-up, where it waits for `vcc_on`.
- R5: After an over-temperature fault, the expiry of the restart timer leads to start-up only while `sd_ok` is high. While `sd_ok` is low the machine stays in code 4.
- R6: `f_cs` and `f_tsd` move the machine to discharging without arming the timer. The next `vcc_off` returns it straight to start-up.
- R7: With `latch_sel` high, `f_wod`, confirmed `f_otp` or `f_aux` move the machine to latched (code 5). It leaves that state only through `vcc_rst`.
- R8: Start-up is blocked until `line_ok` is seen high. While switching, `line_ok` low for BO_BLANK_CYC consecutive cycles stops the drive (code 3). A shorter dip has no effect.
- R9: When `line_ok` returns high after a brown-out, the machine goes to start-up on the next edge without waiting for `vcc_off`.
- R10: When a latched fault and a recoverable fault arrive together, the latched state wins.
- R11: `vcc_rst` sends the machine from any state to start-up on the next edge.
- R12: `vcc_off` seen in the stopped or running state, with no fault present, returns the machine to start-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_on | input | 1 | Supply at or above its start level |
| vcc_off | input | 1 | Supply at or below its stop level |
| vcc_rst | input | 1 | Supply below its reset level; clears the latch |
| line_ok | input | 1 | Line-sense comparator: input above the brown-out threshold |
| f_otp | input | 1 | Raw over-temperature flag |
| f_pin_ovp | input | 1 | Raw programmable over-voltage flag |
| f_vcc_ovp | input | 1 | Supply over-voltage flag |
| f_wod | input | 1 | Winding or output diode short flag |
| f_aux | input | 1 | Auxiliary winding or output short flag |
| f_cs | input | 1 | Current-sense pin short flag |
| f_tsd | input | 1 | Die thermal shutdown flag |
| latch_sel | input | 1 | Selects the latched variant |
| sd_ok | input | 1 | Shutdown pin above its restart level |
| drv_en | output | 1 | Gate driver enable |
| startup_mode | output | 1 | Start-up current mode indicator |
| state_code | output | 3 | Current state code |

## Verification
The bench pulses the filtered faults and the line dip for one cycle less than their thresholds. A design with an off-by-one filter would stop the drive on these too-short events. It also checks the exact edge on which the drive returns after the hold-off, which exposes a hold-off one cycle short or long. The restart timer is left to expire while the over-temperature pin is still low; a machine that ignores that flag would restart too early. Other tests hit the latch with and without the variant select, with a simultaneous recoverable fault, and with brown-out recovery while the supply is still high. A design without the latch priority would drop into recovery, and one without the hiccup bypass would sit in discharge.

// File: rtl/fault_seq.sv
module fault_seq #(
  parameter int HOLD_CYC     = 9000,
  parameter int CONFIRM_CYC  = 1500,
  parameter int RESTART_CYC  = 200_000_000,
  parameter int BO_BLANK_CYC = 2_500_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_on,
  input  logic       vcc_off,
  input  logic       vcc_rst,
  input  logic       line_ok,
  input  logic       f_otp,
  input  logic       f_pin_ovp,
  input  logic       f_vcc_ovp,
  input  logic       f_wod,
  input  logic       f_aux,
  input  logic       f_cs,
  input  logic       f_tsd,
  input  logic       latch_sel,
  input  logic       sd_ok,
  output logic       drv_en,
  output logic       startup_mode,
  output logic [2:0] state_code
);

  localparam int TMAX = (RESTART_CYC > HOLD_CYC) ? RESTART_CYC : HOLD_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int CW   = $clog2(CONFIRM_CYC + 1);
  localparam int BW   = $clog2(BO_BLANK_CYC + 1);

  typedef enum logic [2:0] {
    S_RESET = 3'd0,
    S_STOP  = 3'd1,
    S_RUN   = 3'd2,
    S_DISCH = 3'd3,
    S_TIMER = 3'd4,
    S_LATCH = 3'd5
  } state_t;

  state_t          st, nxt;
  logic [TW-1:0]   tmr;
  logic            need_tmr, otp_pend;
  logic            set_need, set_otp;

  // Persistence filters for over-temperature [0] and pin over-voltage [1]
  logic [1:0] raw_f, conf_f;
  assign raw_f = {f_pin_ovp, f_otp};

  for (genvar g = 0; g < 2; g++) begin : g_conf
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt       <= '0;
        conf_f[g] <= 1'b0;
      end else if (!raw_f[g]) begin
        cnt       <= '0;
        conf_f[g] <= 1'b0;
      end else if (cnt == CW'(CONFIRM_CYC - 1)) begin
        conf_f[g] <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // Line blanking: low line must persist before it counts
  logic [BW-1:0] bo_cnt;
  logic          bo_nok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bo_cnt <= '0;
      bo_nok <= 1'b1;
    end else if (line_ok) begin
      bo_cnt <= '0;
      bo_nok <= 1'b0;
    end else if (bo_cnt == BW'(BO_BLANK_CYC - 1)) begin
      bo_nok <= 1'b1;
    end else begin
      bo_cnt <= bo_cnt + 1'b1;
    end
  end

  wire otp_c     = conf_f[0];
  wire ovp_c     = conf_f[1];
  wire latched_f = latch_sel & (f_wod | otp_c | f_aux);
  wire timer_f   = otp_c | ovp_c | f_vcc_ovp | f_wod | f_aux;
  wire quick_f   = f_cs | f_tsd;
  wire bo_exit   = bo_nok & line_ok;
  wire hold_done = (tmr == TW'(HOLD_CYC - 1));
  wire rst_done  = (tmr == TW'(RESTART_CYC - 1));

  always_comb begin
    nxt      = st;
    set_need = 1'b0;
    set_otp  = 1'b0;
    unique case (st)
      S_RESET: if (vcc_on && !bo_nok) nxt = S_STOP;
      S_STOP, S_RUN: begin
        if (latched_f) nxt = S_LATCH;
        else if (timer_f) begin
          nxt      = S_DISCH;
          set_need = 1'b1;
          set_otp  = otp_c;
        end
        else if (quick_f || bo_nok) nxt = S_DISCH;
        else if (vcc_off) nxt = S_RESET;
        else if (st == S_STOP && hold_done) nxt = S_RUN;
      end
      S_DISCH: begin
        if (bo_exit) nxt = S_RESET;
        else if (vcc_off) nxt = need_tmr ? S_TIMER : S_RESET;
      end
      S_TIMER: begin
        if (bo_exit) nxt = S_RESET;
        else if (rst_done && (!otp_pend || sd_ok)) nxt = S_RESET;
      end
      S_LATCH: nxt = S_LATCH;
      default: nxt = S_RESET;
    endcase
    if (vcc_rst) nxt = S_RESET;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_RESET;
      tmr      <= '0;
      need_tmr <= 1'b0;
      otp_pend <= 1'b0;
    end else begin
      st <= nxt;
      if (nxt != st) tmr <= '0;
      else if ((st == S_STOP && !hold_done) || (st == S_TIMER && !rst_done))
        tmr <= tmr + 1'b1;
      if (nxt == S_RESET) begin
        need_tmr <= 1'b0;
        otp_pend <= 1'b0;
      end else begin
        if (set_need) need_tmr <= 1'b1;
        if (set_otp)  otp_pend <= 1'b1;
      end
    end
  end

  assign drv_en       = (st == S_RUN);
  assign startup_mode = (st == S_RESET);
  assign state_code   = st;

endmodule

// File: rtl/fault_seq_chk.sv
module fault_seq_chk #(
  parameter int HOLD_CYC = 9000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       vcc_off,
  input logic       vcc_rst,
  input logic       latch_sel,
  input logic       drv_en,
  input logic [2:0] state_code
);

  localparam int SW = $clog2(HOLD_CYC + 2);
  logic [SW-1:0] stop_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stop_len <= '0;
    else if (state_code != 3'd1) stop_len <= '0;
    else if (stop_len != SW'(HOLD_CYC + 1)) stop_len <= stop_len + 1'b1;
  end

  p_state_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state_code <= 3'd5);

  p_hold_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd2 && $past(state_code) == 3'd1) |-> (int'(stop_len) >= HOLD_CYC));

  p_drv_from_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en) |-> $past(state_code) == 3'd1);

  p_timer_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd4 && $past(state_code) == 3'd3) |-> $past(vcc_off));

  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd5 && !vcc_rst) |=> state_code == 3'd5);

  p_latch_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd5 && $past(state_code) != 3'd5) |-> $past(latch_sel));

  p_supply_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_rst |=> state_code == 3'd0);

endmodule

bind fault_seq fault_seq_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .vcc_off(vcc_off), .vcc_rst(vcc_rst),
  .latch_sel(latch_sel), .drv_en(drv_en), .state_code(state_code)
);

// File: tb/test_fault_seq.sv
module test_fault_seq;
  localparam time CLK_PERIOD = 10ns;
  localparam int HOLD = 8, CONF = 4, RESTART = 40, BLANK = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vcc_on = 0, vcc_off = 0, vcc_rst = 0, line_ok = 0;
  logic f_otp = 0, f_pin_ovp = 0, f_vcc_ovp = 0, f_wod = 0, f_aux = 0, f_cs = 0, f_tsd = 0;
  logic latch_sel = 0, sd_ok = 1;
  logic drv_en, startup_mode;
  logic [2:0] state_code;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_seq #(.HOLD_CYC(HOLD), .CONFIRM_CYC(CONF), .RESTART_CYC(RESTART),
              .BO_BLANK_CYC(BLANK)) i_fault_seq (
    .clk(clk), .rst_n(rst_n), .vcc_on(vcc_on), .vcc_off(vcc_off), .vcc_rst(vcc_rst),
    .line_ok(line_ok), .f_otp(f_otp), .f_pin_ovp(f_pin_ovp), .f_vcc_ovp(f_vcc_ovp),
    .f_wod(f_wod), .f_aux(f_aux), .f_cs(f_cs), .f_tsd(f_tsd), .latch_sel(latch_sel),
    .sd_ok(sd_ok), .drv_en(drv_en), .startup_mode(startup_mode), .state_code(state_code));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // supply rises from start-up; hold-off then running (R2)
  task automatic bring_up(input string req);
    vcc_off = 0; vcc_on = 1;
    step(HOLD);
    chk({req, " hold state"}, state_code, 1);
    chk({req, " hold drv"}, drv_en, 0);
    step(1);
    chk({req, " run state"}, state_code, 2);
    chk({req, " run drv"}, drv_en, 1);
  endtask

  task automatic t_reset;
    step(2);
    rst_n = 1; #1;
    chk("R1 state", state_code, 0);
    chk("R1 drv", drv_en, 0);
    chk("R1 startup", startup_mode, 1);
    vcc_on = 1;
    step(3);
    chk("R8 no start without line", state_code, 0);
    line_ok = 1;
    step(1);
    chk("R8 line seen", state_code, 0);
    vcc_on = 0;
    bring_up("R2");
  endtask

  task automatic t_filter;
    f_otp = 1; step(CONF - 1); f_otp = 0; step(2);
    chk("R3 short otp ignored", state_code, 2);
    f_pin_ovp = 1; step(CONF);
    chk("R3 ovp at threshold", state_code, 2);
    step(1);
    chk("R3 ovp confirmed", state_code, 3);
    chk("R4 drv off", drv_en, 0);
    f_pin_ovp = 0;
    vcc_on = 0; vcc_off = 1; step(1);
    chk("R4 timer entered", state_code, 4);
    vcc_off = 0; step(RESTART - 1);
    chk("R4 timer running", state_code, 4);
    step(1);
    chk("R4 back to start-up", state_code, 0);
    chk("R4 startup mode", startup_mode, 1);
    step(3);
    chk("R4 waits vcc_on", state_code, 0);
    bring_up("R4");
  endtask

  task automatic t_otp_restart;
    sd_ok = 0; f_otp = 1; step(CONF + 1);
    chk("R5 otp stop", state_code, 3);
    f_otp = 0; vcc_on = 0; vcc_off = 1; step(1);
    vcc_off = 0; step(RESTART + 5);
    chk("R5 held by sd pin", state_code, 4);
    sd_ok = 1; step(1);
    chk("R5 restart after sd ok", state_code, 0);
    bring_up("R5");
  endtask

  task automatic t_quick;
    f_cs = 1; step(1); f_cs = 0;
    chk("R6 cs stop", state_code, 3);
    vcc_on = 0; vcc_off = 1; step(1);
    chk("R6 cs no timer", state_code, 0);
    bring_up("R6");
    f_tsd = 1; step(1); f_tsd = 0;
    chk("R6 tsd stop", state_code, 3);
    vcc_on = 0; vcc_off = 1; step(1);
    chk("R6 tsd no timer", state_code, 0);
    bring_up("R6");
  endtask

  task automatic t_latch;
    latch_sel = 1; f_wod = 1; step(1); f_wod = 0;
    chk("R7 latched", state_code, 5);
    vcc_on = 0; vcc_off = 1; step(3); vcc_off = 0; vcc_on = 1; step(3);
    chk("R7 latch holds", state_code, 5);
    chk("R7 latch drv", drv_en, 0);
    vcc_on = 0; vcc_rst = 1; step(1); vcc_rst = 0;
    chk("R7 released", state_code, 0);
    bring_up("R7");
    f_cs = 1; f_aux = 1; step(1); f_cs = 0; f_aux = 0;
    chk("R10 latch wins", state_code, 5);
    vcc_rst = 1; step(1); vcc_rst = 0;
    latch_sel = 0; vcc_on = 0;
    bring_up("R10");
    f_aux = 1; step(1); f_aux = 0;
    chk("R7 auto variant", state_code, 3);
    vcc_rst = 1; step(1); vcc_rst = 0;
    chk("R11 reset from discharge", state_code, 0);
    vcc_on = 0;
    bring_up("R11");
  endtask

  task automatic t_brownout;
    line_ok = 0; step(BLANK - 1); line_ok = 1; step(2);
    chk("R8 short dip ignored", state_code, 2);
    line_ok = 0; step(BLANK);
    chk("R8 at blank limit", state_code, 2);
    step(1);
    chk("R8 brown-out stop", state_code, 3);
    line_ok = 1; step(1);
    chk("R9 exit to start-up", state_code, 0);
    chk("R9 startup mode", startup_mode, 1);
    step(HOLD + 1);
    chk("R9 running again", state_code, 2);
    vcc_off = 1; vcc_on = 0; step(1); vcc_off = 0;
    chk("R12 undervoltage", state_code, 0);
    bring_up("R12");
  endtask

  initial begin
    t_reset();
    t_filter();
    t_otp_restart();
    t_quick();
    t_latch();
    t_brownout();
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    report();
  end
endmodule